// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit performs the virtual machine's atomic memory instructions on a single-port synchronous memory of 64-bit words. A request names the target word as a base value plus a signed 16-bit displacement, and it carries an operand size code, the 8-bit operation code from the immediate field, the source register value and the R0 value. The unit reads the word, computes the new value, writes it back and then reports the values that go back to the register file. A lock output stays high for the whole read-to-write window, so that an external arbiter can keep other accesses out.

Three kinds of operation are supported. The simple operations (add, or, and, xor) can optionally fetch the old memory value into the source register. Exchange stores the source value and returns the old value. Compare-exchange stores the source value only when memory equals R0, and in both outcomes it returns the old value to R0. A 32-bit mode works on the low half of the word only. An unknown operation code or an unsupported size is rejected with an error pulse and causes no memory access.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, lock, done, error, mem_rd, mem_wr, src_we and r0_we are all low.
- R2: The memory word index is base_addr plus the 16-bit offset sign-extended to ADDR_W bits, with the sum wrapping modulo 2^ADDR_W.
- R3: The low nibble of op selects fetch (bit 0) and the high nibble selects the function: 0x0 add, 0x4 or, 0x5 and, 0xa xor. The word written back is the old word combined with the source value by that function.
- R4: When op bit 0 is set on a simple operation, src_we pulses with src_wdata equal to the old memory value. When the bit is clear, no register write-back takes place.
- R5: Exchange (op 0xe1) writes the source value to memory and returns the old value through src_we/src_wdata.
- R6: Compare-exchange (op 0xf1) writes the source value only when the old word equals R0, and otherwise makes no write. In both cases r0_we pulses with r0_wdata equal to the zero-extended old value, and src_we stays low.
- R7: Size code 0 selects 32-bit mode and size code 3 selects 64-bit mode. In 32-bit mode only bits 31:0 of the word are computed and compared, bits 63:32 of memory are written back unchanged, and returned values are zero-extended.
- R8: Size codes 1 and 2, and any op other than 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1 or 0xf1, are illegal. An illegal request produces a one-cycle error pulse in the cycle after it is accepted, with no memory read or write and no register write-back.
- R9: For a legal request taken at a clock edge, mem_rd is high in the next cycle. lock is high for exactly that cycle and the two that follow, mem_wr (when a write takes place) falls in the third of them, and done pulses in the fourth cycle together with the write-back enables.
- R10: start is ignored while a request is in progress. No second operation, memory access or error results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| base_addr | input | ADDR_W | Base word index from the destination register |
| offset | input | 16 | Signed displacement |
| size | input | 2 | Operand size code (0 = 32-bit, 3 = 64-bit) |
| op | input | 8 | Atomic operation code |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | R0 value for compare-exchange |
| mem_addr | output | ADDR_W | Memory word index |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 64 | Read data, valid the cycle after mem_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 64 | Write data |
| lock | output | 1 | Memory held for the read-modify-write |
| done | output | 1 | Completion pulse |
| error | output | 1 | Illegal-request pulse |
| src_we | output | 1 | Source register write enable |
| src_wdata | output | 64 | Value for the source register |
| r0_we | output | 1 | R0 write enable |
| r0_wdata | output | 64 | Value for R0 |

## Verification
The two functions that can fall in the same cycle are an operation already locked in flight and a new start strobe. The bench raises start with a different legal request during the modify cycle and keeps it up through the write cycle. It then checks that exactly one memory write took place, that the second target word is unchanged and that no error pulse appeared. A second pairing, a compare-exchange miss that returns R0 while it suppresses the write, is checked in the same way through the write count and the returned value.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [15:0]       offset,
  input  logic [1:0]        size,
  input  logic [7:0]        op,
  input  logic [63:0]       src_val,
  input  logic [63:0]       r0_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [63:0]       mem_rdata,
  output logic              mem_wr,
  output logic [63:0]       mem_wdata,
  output logic              lock,
  output logic              done,
  output logic              error,
  output logic              src_we,
  output logic [63:0]       src_wdata,
  output logic              r0_we,
  output logic [63:0]       r0_wdata
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MOD, S_WRITE, S_DONE} st_t;
  st_t state;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]  op_q;
  logic [63:0] src_q, r0_q, old_q;
  logic        wide_q, err_q;

  logic size_ok, op_ok, legal;
  assign size_ok = (size == 2'd0) || (size == 2'd3);
  always_comb begin
    case (op)
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
      8'ha0, 8'ha1, 8'he1, 8'hf1: op_ok = 1'b1;
      default:                    op_ok = 1'b0;
    endcase
  end
  assign legal = size_ok && op_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      err_q  <= 1'b0;
      addr_q <= '0;
      op_q   <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      old_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (legal) begin
            state  <= S_READ;
            addr_q <= base_addr + ADDR_W'(signed'(offset));
            op_q   <= op;
            src_q  <= src_val;
            r0_q   <= r0_val;
            wide_q <= (size == 2'd3);
          end else begin
            err_q <= 1'b1;
          end
        end
        S_READ:  state <= S_MOD;
        S_MOD: begin
          old_q <= mem_rdata;
          state <= S_WRITE;
        end
        S_WRITE: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [63:0] a_op, s_op, res, fetched;
  logic        is_cmpx, cmp_hit, do_write;
  assign a_op    = wide_q ? old_q : {32'b0, old_q[31:0]};
  assign s_op    = wide_q ? src_q : {32'b0, src_q[31:0]};
  assign fetched = a_op;
  assign is_cmpx = (op_q[7:4] == 4'hf);
  assign cmp_hit = wide_q ? (old_q == r0_q) : (old_q[31:0] == r0_q[31:0]);
  assign do_write = !is_cmpx || cmp_hit;

  always_comb begin
    case (op_q[7:4])
      4'h0:    res = a_op + s_op;
      4'h4:    res = a_op | s_op;
      4'h5:    res = a_op & s_op;
      4'ha:    res = a_op ^ s_op;
      default: res = s_op;
    endcase
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = (state == S_READ);
  assign mem_wr    = (state == S_WRITE) && do_write;
  assign mem_wdata = wide_q ? res : {old_q[63:32], res[31:0]};
  assign lock      = (state == S_READ) || (state == S_MOD) || (state == S_WRITE);
  assign done      = (state == S_DONE);
  assign error     = err_q;
  assign src_we    = done && op_q[0] && !is_cmpx;
  assign src_wdata = fetched;
  assign r0_we     = done && is_cmpx;
  assign r0_wdata  = fetched;

  // R9
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  // R9
  lock_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> done);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!lock && !mem_rd && !mem_wr && !src_we && !r0_we));

  // R4
  wb_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we || r0_we) |-> (done && $past(lock)));

  // R6
  single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_we, r0_we}));

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_atomic_rmw_unit.sv
`timescale 1ns/1ps
module tb_atomic_rmw_unit;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [15:0] offset = '0;
  logic [1:0] size = '0;
  logic [7:0] op = '0;
  logic [63:0] src_val = '0, r0_val = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, lock, done, error, src_we, r0_we;
  logic [63:0] mem_rdata = '0, mem_wdata, src_wdata, r0_wdata;

  always #4 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .offset(offset), .size(size), .op(op), .src_val(src_val), .r0_val(r0_val),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .lock(lock), .done(done),
    .error(error), .src_we(src_we), .src_wdata(src_wdata),
    .r0_we(r0_we), .r0_wdata(r0_wdata));

  logic [63:0] mem [16];
  logic poke_en = 1'b0;
  logic [3:0] poke_idx = '0;
  logic [63:0] poke_val = '0;
  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_val;
    else if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
  end

  int total = 0, fails = 0;
  int done_k, err_k, rd_cnt, wr_cnt;
  bit lock_ok, s_we, z_we;
  logic [63:0] s_d, z_d;
  logic [AW-1:0] addr_seen;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [3:0] idx, input logic [63:0] v);
    @(negedge clk); poke_en = 1'b1; poke_idx = idx; poke_val = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] b, input logic [15:0] off, input logic [1:0] sz,
                     input logic [7:0] o, input logic [63:0] s, input logic [63:0] r,
                     input bit busy_poke);
    @(negedge clk);
    base_addr = b; offset = off; size = sz; op = o; src_val = s; r0_val = r; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    done_k = 0; err_k = 0; rd_cnt = 0; wr_cnt = 0; lock_ok = 1'b1;
    s_we = 0; z_we = 0; s_d = '0; z_d = '0; addr_seen = '0;
    for (int k = 1; k <= 8; k++) begin
      if (mem_rd) begin rd_cnt++; addr_seen = mem_addr; end
      if (mem_wr) wr_cnt++;
      if (error && err_k == 0) err_k = k;
      if (done) begin done_k = k; s_we = src_we; s_d = src_wdata; z_we = r0_we; z_d = r0_wdata; end
      if (lock !== (k <= 3)) lock_ok = 1'b0;
      if (busy_poke && k == 2) begin
        base_addr = 16'd9; offset = 16'd0; size = 2'd3; op = 8'h00; src_val = 64'd5; start = 1'b1;
      end
      if (busy_poke && k == 3) start = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!lock && !done && !error && !mem_rd && !mem_wr && !src_we && !r0_we,
        "R1 reset outputs", {57'b0, lock, done, error, mem_rd, mem_wr, src_we, r0_we}, 64'd0);
  endtask

  task automatic t_add64;
    poke(4'd2, 64'hFFFF_FFFF_FFFF_FFFE);
    run(16'd2, 16'd0, 2'd3, 8'h00, 64'd3, 64'd0, 1'b0);
    chk(mem[2] == 64'd1, "R3 add64 result", mem[2], 64'd1);
    chk(!s_we && !z_we, "R4 no fetch no writeback", {62'b0, s_we, z_we}, 64'd0);
    chk(done_k == 4 && lock_ok && rd_cnt == 1 && wr_cnt == 1, "R9 timing",
        64'(done_k), 64'd4);
  endtask

  task automatic t_logic;
    poke(4'd3, 64'hF0F0_0000_1234_5678);
    run(16'd3, 16'd0, 2'd3, 8'h41, 64'h0F00_0000_0000_0001, 64'd0, 1'b0);
    chk(mem[3] == 64'hFFF0_0000_1234_5679, "R3 or64", mem[3], 64'hFFF0_0000_1234_5679);
    chk(s_we && s_d == 64'hF0F0_0000_1234_5678, "R4 fetch old", s_d, 64'hF0F0_0000_1234_5678);
    run(16'd3, 16'd0, 2'd3, 8'h51, 64'hFF00_0000_0000_00FF, 64'd0, 1'b0);
    chk(mem[3] == 64'hFF00_0000_0000_0079, "R3 and64", mem[3], 64'hFF00_0000_0000_0079);
    run(16'd3, 16'd0, 2'd3, 8'ha0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    chk(mem[3] == 64'h00FF_FFFF_FFFF_FF86, "R3 xor64", mem[3], 64'h00FF_FFFF_FFFF_FF86);
  endtask

  task automatic t_addr;
    poke(4'd13, 64'd100);
    run(16'h0010, 16'hFFFD, 2'd3, 8'h01, 64'd1, 64'd0, 1'b0);
    chk(addr_seen == 16'h000D, "R2 negative offset", 64'(addr_seen), 64'h000D);
    chk(mem[13] == 64'd101 && s_d == 64'd100, "R2 target word", mem[13], 64'd101);
    run(16'hFFFF, 16'h0003, 2'd3, 8'h00, 64'd0, 64'd0, 1'b0);
    chk(addr_seen == 16'h0002, "R2 wrap", 64'(addr_seen), 64'h0002);
  endtask

  task automatic t_xchg;
    poke(4'd5, 64'hDEAD_BEEF_0000_0001);
    run(16'd5, 16'd0, 2'd3, 8'he1, 64'h1111_2222_3333_4444, 64'd0, 1'b0);
    chk(mem[5] == 64'h1111_2222_3333_4444, "R5 xchg store", mem[5], 64'h1111_2222_3333_4444);
    chk(s_we && !z_we && s_d == 64'hDEAD_BEEF_0000_0001, "R5 xchg return", s_d, 64'hDEAD_BEEF_0000_0001);
  endtask

  task automatic t_cmpx;
    poke(4'd6, 64'h55);
    run(16'd6, 16'd0, 2'd3, 8'hf1, 64'h77, 64'h55, 1'b0);
    chk(mem[6] == 64'h77 && wr_cnt == 1, "R6 cmpxchg hit store", mem[6], 64'h77);
    chk(z_we && !s_we && z_d == 64'h55, "R6 cmpxchg hit r0", z_d, 64'h55);
    run(16'd6, 16'd0, 2'd3, 8'hf1, 64'h99, 64'h55, 1'b0);
    chk(mem[6] == 64'h77 && wr_cnt == 0, "R6 cmpxchg miss no write", mem[6], 64'h77);
    chk(z_we && z_d == 64'h77, "R6 cmpxchg miss r0", z_d, 64'h77);
  endtask

  task automatic t_w32;
    poke(4'd7, 64'hAAAA_BBBB_FFFF_FFFF);
    run(16'd7, 16'd0, 2'd0, 8'h01, 64'hFFFF_0000_0000_0001, 64'd0, 1'b0);
    chk(mem[7] == 64'hAAAA_BBBB_0000_0000, "R7 add32 upper kept", mem[7], 64'hAAAA_BBBB_0000_0000);
    chk(s_d == 64'h0000_0000_FFFF_FFFF, "R7 fetch zero-extended", s_d, 64'h0000_0000_FFFF_FFFF);
    poke(4'd8, 64'h1234_5678_0000_00AA);
    run(16'd8, 16'd0, 2'd0, 8'hf1, 64'hFFFF_FFFF_0000_00BB, 64'h9999_9999_0000_00AA, 1'b0);
    chk(mem[8] == 64'h1234_5678_0000_00BB, "R7 cmpxchg32 low compare", mem[8], 64'h1234_5678_0000_00BB);
    chk(z_d == 64'h0000_0000_0000_00AA, "R7 cmpxchg32 r0 zero-ext", z_d, 64'hAA);
  endtask

  task automatic t_illegal;
    poke(4'd4, 64'h42);
    run(16'd4, 16'd0, 2'd1, 8'h00, 64'd1, 64'd0, 1'b0);
    chk(err_k == 1 && rd_cnt == 0 && wr_cnt == 0 && done_k == 0, "R8 bad size", 64'(err_k), 64'd1);
    run(16'd4, 16'd0, 2'd3, 8'h02, 64'd1, 64'd0, 1'b0);
    chk(err_k == 1 && rd_cnt == 0 && done_k == 0, "R8 bad op", 64'(err_k), 64'd1);
    run(16'd4, 16'd0, 2'd3, 8'he0, 64'd1, 64'd0, 1'b0);
    chk(err_k == 1 && wr_cnt == 0 && mem[4] == 64'h42, "R8 xchg without fetch", mem[4], 64'h42);
  endtask

  task automatic t_busy;
    poke(4'd9, 64'd1000);
    poke(4'd10, 64'd20);
    run(16'd10, 16'd0, 2'd3, 8'h00, 64'd2, 64'd0, 1'b1);
    chk(mem[9] == 64'd1000 && mem[10] == 64'd22, "R10 start ignored while busy", mem[9], 64'd1000);
    chk(wr_cnt == 1 && rd_cnt == 1 && err_k == 0, "R10 single access", 64'(wr_cnt), 64'd1);
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add64();
    t_logic();
    t_addr();
    t_xchg();
    t_cmpx();
    t_w32();
    t_illegal();
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule